// File: doc/BRIEF.md
# Byte-Serial Instruction Decoder

This block turns a stream of instruction bytes for a small 8-bit accumulator machine into decoded records. Bytes come in over a valid/ready handshake.

Each opcode byte is split into a 5-bit group in bits 7:3 and a 3-bit operand in bits 2:0. Most instructions are a single byte. The two groups with binary 1111x in bits 7:3 are extended forms. For these the block stores the opcode byte, waits for a second byte holding the immediate, and only then emits the record.

For every complete instruction the block raises `out_valid` for exactly one cycle. The record carries:
- an instruction class;
- an operation sub-code;
- a register index;
- a special-register selector;
- the load/store, data-pointer and flag bits of a memory access;
- the immediate;
- an error code that marks invalid encodings, reserved encodings and a missing operand.

An end-of-stream input tells the block that no more bytes will come. If that happens while an extended instruction still lacks its immediate, the block reports a missing operand. The consumer must accept a record in the cycle it appears. While the consumer holds `out_ready` low, the block accepts no bytes.

Top module: `insn_decoder`

## Requirements
- R1: After synchronous reset `out_valid` is 0 and any partly collected extended instruction is dropped. The next accepted byte is decoded as an opcode. Example: reset while waiting, then send 0x01, and the block emits class 2.
- R2: A byte is accepted when `in_valid` and `in_ready` are both 1. `in_ready` is 0 whenever `out_ready` is 0. A record appears with `out_valid`=1 in the cycle after the byte that completes the instruction is accepted, and `out_valid` lasts one cycle only.
- R3: Group 00000 (bits 7:3) decodes operand 000 as class 1 (stop), operand 001 as class 2 (no-op), operand 010 as class 3 (print), operand 110 as class 4 (absolute jump from accumulator) and operand 111 as class 5 (relative jump from accumulator). Operands 011, 100 and 101 give error code 1 (invalid).
- R4: Group 00001 gives class 6 (single-operand ALU) with `out_op` = the operand bits 2:0.
- R5: Group 00010 gives class 7 (get special) and group 00011 gives class 8 (set special), with `out_sel` = operand bits 1:0. The selector values are 0 = data pointer 1, 1 = data pointer 2 and 2 = code pointer. Operand 011 gives error 2 (reserved). Operands 1xx give error 1.
- R6: Groups 00100, 00101, 00110 and 00111 give classes 9 (get register), 10 (set register), 11 (swap) and 12 (less-than), with `out_reg` = bits 2:0.
- R7: Bytes with bits 7:6 = 01 give class 13 (register ALU), with `out_op` = bits 5:3 and `out_reg` = bits 2:0.
- R8: Bytes with bits 7:6 = 10 give class 14 (memory access), with:
  - `out_store` = bit 3 (1 = store);
  - `out_flag` = bit 4;
  - `out_dp2` = bit 5 (1 = data pointer 2);
  - `out_reg` = bits 2:0.
- R9: Bytes with bits 7:4 = 1111 are two-byte instructions. The opcode byte produces no record. The next accepted byte becomes `out_imm`, and the record has class 15 with `out_op` = opcode bits 3:0. The valid nibbles are 0 AND, 1 OR, 2 XOR, 3 add/compact, 4 branch-if-zero, 5 reserved jump, 6 absolute jump, 7 relative jump and 14 load immediate. For nibble 3, `out_flag` = 1 exactly when the immediate's bits 7:6 are 10 (compact form).
- R10: For a two-byte opcode with nibble 8 to 13 or 15, the block still collects the immediate byte and then emits error 2. Groups 11000 through 11101 give error 1 and are single bytes.
- R11: If `in_eos` is 1 while waiting for an immediate, the block accepts no byte, emits a record with error 3 (missing operand) when `out_ready` is 1, and returns to idle. `in_eos` while idle has no effect.
- R12: Every record with a nonzero error code has all other fields zero, including class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Input byte |
| in_eos | input | 1 | End of byte stream |
| in_ready | output | 1 | Block can take a byte |
| out_ready | input | 1 | Consumer can take a record |
| out_valid | output | 1 | One-cycle record strobe |
| out_class | output | 4 | Instruction class |
| out_op | output | 4 | Operation sub-code |
| out_reg | output | 3 | Register index |
| out_sel | output | 2 | Special-register selector |
| out_store | output | 1 | Memory access is a store |
| out_dp2 | output | 1 | Memory access uses data pointer 2 |
| out_flag | output | 1 | Memory extra flag, or compact form of extended add |
| out_imm | output | 8 | Immediate byte |
| out_err | output | 2 | 0 none, 1 invalid, 2 reserved, 3 missing operand |

## Verification
The block has no parameters, so the bench builds it as it stands. The opcode space is only 256 values, so every opcode byte is swept and each record is compared field by field with a decode worked out arithmetically from the group and operand numbers. Each two-byte opcode is followed by an immediate derived from it. The compact and plain forms of the extended add are both covered, as are stalls, end of stream in both states and reset in the middle of an instruction.

// File: rtl/insn_decoder.sv
module insn_decoder (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       in_eos,
  output logic       in_ready,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [3:0] out_class,
  output logic [3:0] out_op,
  output logic [2:0] out_reg,
  output logic [1:0] out_sel,
  output logic       out_store,
  output logic       out_dp2,
  output logic       out_flag,
  output logic [7:0] out_imm,
  output logic [1:0] out_err
);

  logic       wait_q;
  logic [7:0] held_q;
  logic [7:0] opb;
  logic [4:0] grp;
  logic [2:0] opd;
  logic       two_byte, accept, missing;

  logic [3:0] d_cls, d_op;
  logic [2:0] d_reg;
  logic [1:0] d_sel, d_err;
  logic       d_st, d_dp, d_fl;
  logic [7:0] d_imm;

  assign opb      = wait_q ? held_q : in_byte;
  assign grp      = opb[7:3];
  assign opd      = opb[2:0];
  assign two_byte = (in_byte[7:4] == 4'b1111);
  assign missing  = wait_q && in_eos;
  assign in_ready = out_ready && !missing;
  assign accept   = in_valid && in_ready;

  always_comb begin
    d_cls = 4'd0; d_op = 4'd0; d_reg = 3'd0; d_sel = 2'd0;
    d_st = 1'b0; d_dp = 1'b0; d_fl = 1'b0; d_imm = 8'd0; d_err = 2'd0;
    if (grp == 5'b00000) begin
      case (opd)
        3'b000:  d_cls = 4'd1;
        3'b001:  d_cls = 4'd2;
        3'b010:  d_cls = 4'd3;
        3'b110:  d_cls = 4'd4;
        3'b111:  d_cls = 4'd5;
        default: d_err = 2'd1;
      endcase
    end else if (grp == 5'b00001) begin
      d_cls = 4'd6;
      d_op  = {1'b0, opd};
    end else if (grp[4:1] == 4'b0001) begin
      if (opd[2])            d_err = 2'd1;
      else if (opd == 3'b011) d_err = 2'd2;
      else begin
        d_cls = grp[0] ? 4'd8 : 4'd7;
        d_sel = opd[1:0];
      end
    end else if (grp[4:2] == 3'b001) begin
      d_cls = 4'd9 + {2'b00, grp[1:0]};
      d_reg = opd;
    end else if (grp[4:3] == 2'b01) begin
      d_cls = 4'd13;
      d_op  = {1'b0, opb[5:3]};
      d_reg = opd;
    end else if (grp[4:3] == 2'b10) begin
      d_cls = 4'd14;
      d_st  = opb[3];
      d_fl  = opb[4];
      d_dp  = opb[5];
      d_reg = opd;
    end else if (grp[4:1] == 4'b1111) begin
      if (opb[3] && opb[3:0] != 4'd14) d_err = 2'd2;
      else begin
        d_cls = 4'd15;
        d_op  = opb[3:0];
        d_imm = in_byte;
        d_fl  = (opb[3:0] == 4'd3) && (in_byte[7:6] == 2'b10);
      end
    end else begin
      d_err = 2'd1;
    end
    if (d_err != 2'd0) begin
      d_cls = 4'd0; d_op = 4'd0; d_reg = 3'd0; d_sel = 2'd0;
      d_st = 1'b0; d_dp = 1'b0; d_fl = 1'b0; d_imm = 8'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q    <= 1'b0;
      held_q    <= 8'd0;
      out_valid <= 1'b0;
      out_class <= 4'd0; out_op <= 4'd0; out_reg <= 3'd0; out_sel <= 2'd0;
      out_store <= 1'b0; out_dp2 <= 1'b0; out_flag <= 1'b0;
      out_imm   <= 8'd0; out_err <= 2'd0;
    end else begin
      out_valid <= 1'b0;
      if (missing && out_ready) begin
        wait_q    <= 1'b0;
        out_valid <= 1'b1;
        out_class <= 4'd0; out_op <= 4'd0; out_reg <= 3'd0; out_sel <= 2'd0;
        out_store <= 1'b0; out_dp2 <= 1'b0; out_flag <= 1'b0;
        out_imm   <= 8'd0; out_err <= 2'd3;
      end else if (accept) begin
        if (!wait_q && two_byte) begin
          wait_q <= 1'b1;
          held_q <= in_byte;
        end else begin
          wait_q    <= 1'b0;
          out_valid <= 1'b1;
          out_class <= d_cls; out_op <= d_op; out_reg <= d_reg; out_sel <= d_sel;
          out_store <= d_st; out_dp2 <= d_dp; out_flag <= d_fl;
          out_imm   <= d_imm; out_err <= d_err;
        end
      end
    end
  end

  // R2
  valid_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(out_ready));

  // R2
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(out_valid) && !(in_valid && in_ready) && !(missing && out_ready)) |=> !out_valid);

  // R12
  err_zero_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err != 2'd0) |-> (out_class == 4'd0 && out_op == 4'd0 &&
      out_reg == 3'd0 && out_imm == 8'd0 && !out_flag && !out_store && !out_dp2));

  // R11
  missing_from_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err == 2'd3) |-> $past(wait_q && in_eos));

  // R9
  ext_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 4'd15) |-> $past(wait_q));

  // R9
  wait_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_q && !(in_valid && in_ready) && !(in_eos && out_ready)) |=> (wait_q && $stable(held_q)));

endmodule

// File: tb/insn_decoder_tb.sv
module insn_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_eos = 1'b0, out_ready = 1'b1;
  logic [7:0] in_byte = 8'd0;
  logic in_ready, out_valid, out_store, out_dp2, out_flag;
  logic [3:0] out_class, out_op;
  logic [2:0] out_reg;
  logic [1:0] out_sel, out_err;
  logic [7:0] out_imm;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_decoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_eos(in_eos),
    .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_class(out_class), .out_op(out_op), .out_reg(out_reg), .out_sel(out_sel),
    .out_store(out_store), .out_dp2(out_dp2), .out_flag(out_flag),
    .out_imm(out_imm), .out_err(out_err)
  );

  function automatic logic [27:0] rec();
    return {out_valid, out_class, out_op, out_reg, out_sel, out_store, out_dp2,
            out_flag, out_imm, out_err};
  endfunction

  function automatic logic [27:0] pack(int cls, int op, int rg, int sel, int st,
                                       int dp, int fl, int im, int er);
    logic [27:0] r;
    r = {1'b1, 4'(cls), 4'(op), 3'(rg), 2'(sel), 1'(st), 1'(dp), 1'(fl), 8'(im), 2'(er)};
    return r;
  endfunction

  function automatic logic [27:0] expect_rec(int b, int im);
    int g = b / 8, o = b % 8, n = b % 16;
    if (g == 0) begin
      if (o == 0) return pack(1,0,0,0,0,0,0,0,0);
      if (o == 1) return pack(2,0,0,0,0,0,0,0,0);
      if (o == 2) return pack(3,0,0,0,0,0,0,0,0);
      if (o == 6) return pack(4,0,0,0,0,0,0,0,0);
      if (o == 7) return pack(5,0,0,0,0,0,0,0,0);
      return pack(0,0,0,0,0,0,0,0,1);
    end
    if (g == 1) return pack(6,o,0,0,0,0,0,0,0);
    if (g == 2 || g == 3) begin
      if (o >= 4) return pack(0,0,0,0,0,0,0,0,1);
      if (o == 3) return pack(0,0,0,0,0,0,0,0,2);
      return pack(g + 5,0,0,o,0,0,0,0,0);
    end
    if (g >= 4 && g <= 7) return pack(g + 5,0,o,0,0,0,0,0,0);
    if (g >= 8 && g <= 15) return pack(13,g - 8,o,0,0,0,0,0,0);
    if (g >= 16 && g <= 23)
      return pack(14,0,o,0,(b/8)%2,(b/32)%2,(b/16)%2,0,0);
    if (g >= 30) begin
      if (n <= 7 || n == 14)
        return pack(15,n,0,0,0,0,(n == 3 && im/64 == 2) ? 1 : 0,im,0);
      return pack(0,0,0,0,0,0,0,0,2);
    end
    return pack(0,0,0,0,0,0,0,0,1);
  endfunction

  task automatic chk(string req, logic [27:0] got, logic [27:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle_cycle();
    @(posedge clk); #1;
  endtask

  function automatic string req_of(int b);
    int g = b / 8;
    if (g == 0) return "R3";
    if (g == 1) return "R4";
    if (g <= 3) return "R5";
    if (g <= 7) return "R6";
    if (g <= 15) return "R7";
    if (g <= 23) return "R8";
    if (g <= 29) return "R10";
    if (((b % 16) >= 8 && (b % 16) != 14)) return "R10";
    return "R9";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", {27'd0, out_valid}, 28'd0);
    @(negedge clk); rst = 1'b0;
    #1 chk("R1 ready after reset", {27'd0, in_ready}, 28'd1);

    for (int b = 0; b < 256; b++) begin
      int im = (b * 37 + 11) % 256;
      if (b / 16 == 15) begin
        send(8'(b));
        chk("R9 no record on opcode byte", {27'd0, out_valid}, 28'd0);
        send(8'(im));
      end else send(8'(b));
      chk(req_of(b), rec(), expect_rec(b, im));
      idle_cycle();
      chk("R2 one-cycle pulse", {27'd0, out_valid}, 28'd0);
    end

    for (int im = 0; im < 256; im += 16) begin
      send(8'hF3); send(8'(im));
      chk("R9 compact flag", rec(), expect_rec(8'hF3, im));
    end

    send(8'hF4);
    @(negedge clk); in_eos = 1'b1; in_valid = 1'b1; in_byte = 8'h12;
    #1 chk("R11 no accept on eos", {27'd0, in_ready}, 28'd0);
    @(posedge clk); #1;
    in_eos = 1'b0; in_valid = 1'b0;
    chk("R11 missing operand", rec(), pack(0,0,0,0,0,0,0,0,3));
    send(8'h22);
    chk("R11 back to idle", rec(), expect_rec(8'h22, 0));

    @(negedge clk); in_eos = 1'b1;
    @(posedge clk); #1;
    chk("R11 eos idle no record", {27'd0, out_valid}, 28'd0);
    in_eos = 1'b0;
    send(8'h01);
    chk("R11 eos idle no effect", rec(), expect_rec(8'h01, 0));

    @(negedge clk); out_ready = 1'b0; in_valid = 1'b1; in_byte = 8'h02;
    #1 chk("R2 ready low on stall", {27'd0, in_ready}, 28'd0);
    @(posedge clk); #1;
    chk("R2 no record on stall", {27'd0, out_valid}, 28'd0);
    in_valid = 1'b0;
    @(negedge clk); out_ready = 1'b1;
    send(8'h02);
    chk("R2 after stall", rec(), expect_rec(8'h02, 0));

    send(8'hF0); send(8'h55);
    chk("R9 AND imm", rec(), pack(15,0,0,0,0,0,0,8'h55,0));
    send(8'hFE);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset mid instruction", {27'd0, out_valid}, 28'd0);
    @(negedge clk); rst = 1'b0;
    send(8'h01);
    chk("R1 partial cleared", rec(), expect_rec(8'h01, 0));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule